// File: doc/BRIEF.md
# MDIO Management Master

This block runs single register transactions toward an Ethernet PHY over the two-wire management bus. A host pulses `start` with the access direction, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then produces the complete serial frame on its own. It derives the management clock from the system clock, drives the data line through an output enable, and samples the line for read data. When the frame ends it raises `done` for one cycle, with the read value and an error flag.

Every frame starts with a full run of idle-high bits. On a read, the block looks at the turnaround bit to tell whether a PHY answered. If the line is not pulled low there, the block treats the address as empty: it keeps clocking with the line released for 32 more cycles, then reports all-ones data with the error flag set. The pad is outside the block. It appears as a separate output value, output enable and input sample.

Top module: `mdio_master`

## Requirements
- R1: Each frame opens with 32 management clock cycles during which the block drives the data line high.
- R2: After that run come the start pair 0,1 and then the direction pair, where 1,0 means read and 0,1 means write. All four bits are driven.
- R3: The PHY address follows, then the register address. Each is 5 bits, sent most significant bit first.
- R4: The driven value and the output enable change only together with a falling clock edge, or while the clock is low. Both are held across every high phase.
- R5: A write drives the turnaround as 1 then 0 and sends the 16 data bits most significant first. It then adds one cycle with the line released, so the frame is 65 clock cycles long.
- R6: A read releases the line from the first turnaround cycle and expects it low at the end of that cycle's high phase. It then captures 16 bits, most significant first, each at the end of a high phase, and adds one trailing cycle. The frame is 64 cycles long, `rd_data` holds the captured value and `err` stays 0.
- R7: If the line is high at the turnaround sample, the block runs 32 more cycles with the line released. It then finishes with `rd_data` = 0xFFFF and `err` = 1, for a frame of 79 cycles. `err` rises only in a `done` cycle.
- R8: Each clock half lasts DIV system clocks. A frame of S cycles therefore takes 2·DIV·S system clocks from the edge that accepts `start` to the edge that raises `done`.
- R9: `start` has no effect while `busy` is high. The frame in progress keeps its fields and length, and no second frame follows it.
- R10: `done` is high for exactly one cycle, and `busy` is low in that cycle. `err` reads 0 from the first busy cycle of every transaction.
- R11: After reset and between frames, the clock rests high and the output enable is low. Reset clears `busy`, `done`, `err` and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a transaction (taken only when idle) |
| op_read | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Value to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Result of the last read |
| err | output | 1 | Last read found no PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line sample from the pad |

## Verification
The assertions take three things for granted. `mdio_i` is the resolved pad value. The PHY side drives only while `mdio_oe` is low. Any change on the line lands while the clock is low, so the value is settled through each high phase in which the block samples. The bench keeps to this with a PHY model that reacts only to falling clock edges and releases the line unless the frame is a read aimed at a present PHY. A pull-up supplies the high level otherwise. `start` is driven only after reset is released. When it is pulsed during a frame, the address and data inputs are changed along with it, so that any effect of that pulse would show up in the captured frame.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

    // protocol constants of a single management frame
    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 16;
    localparam int PRE_SLOTS   = 32;
    localparam int HDR_BITS    = 4 + 2 * ADDR_W;
    localparam int TA_SLOTS    = 2;
    localparam int FLUSH_SLOTS = 32;
    localparam int IDX_W       = 6;

    // frame segments, in transmit order
    typedef enum logic [2:0] {
        SEG_PRE,
        SEG_HDR,
        SEG_TA,
        SEG_DATA,
        SEG_TAIL,
        SEG_FLUSH
    } seg_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;

    typedef struct packed {
        logic mdc;
        logic oe;
        logic dout;
    } pad_drive_t;

    // start pair, direction pair, PHY address, register address; MSB goes first
    function automatic logic [HDR_BITS-1:0] frame_header(input mdio_req_t q);
        logic [1:0] dir;
        dir = q.rd ? 2'b10 : 2'b01;
        return {2'b01, dir, q.phy, q.regn};
    endfunction

endpackage

// File: rtl/mdio_half_timer.sv
`timescale 1ns/1ps
module mdio_half_timer #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic half_end
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign half_end = run && (cnt_q == LAST);

endmodule

// File: rtl/mdio_rx_shift.sv
`timescale 1ns/1ps
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (shift) begin
            q <= {q[W-2:0], din};
        end
    end
endmodule

// File: rtl/mdio_frame_ctrl.sv
`timescale 1ns/1ps
module mdio_frame_ctrl
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              half_end,
    input  logic              din,
    input  logic [DATA_W-1:0] cap_q,
    output logic              cap_clr,
    output logic              cap_shift,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output pad_drive_t        pad
);
    localparam logic [IDX_W-1:0] PRE_LAST   = IDX_W'(PRE_SLOTS - 1);
    localparam logic [IDX_W-1:0] HDR_LAST   = IDX_W'(HDR_BITS - 1);
    localparam logic [IDX_W-1:0] TA_LAST    = IDX_W'(TA_SLOTS - 1);
    localparam logic [IDX_W-1:0] DATA_LAST  = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] FLUSH_LAST = IDX_W'(FLUSH_SLOTS - 1);

    logic                busy_q, half_q, rd_q, done_q, err_q;
    seg_e                seg_q, seg_n;
    logic [IDX_W-1:0]    idx_q, idx_n;
    logic [HDR_BITS-1:0] hdr_sr;
    logic [DATA_W-1:0]   wd_sr, rdata_q;
    logic                fin, fin_err, shift_hdr, shift_wd, cap_in_slot;
    logic                slot_end;

    assign slot_end = busy_q && half_end && half_q;

    // what happens when the current bit slot closes
    always_comb begin
        seg_n       = seg_q;
        idx_n       = idx_q + 1'b1;
        fin         = 1'b0;
        fin_err     = 1'b0;
        shift_hdr   = 1'b0;
        shift_wd    = 1'b0;
        cap_in_slot = 1'b0;
        unique case (seg_q)
            SEG_PRE: begin
                if (idx_q == PRE_LAST) begin
                    seg_n = SEG_HDR;
                    idx_n = '0;
                end
            end
            SEG_HDR: begin
                shift_hdr = 1'b1;
                if (idx_q == HDR_LAST) begin
                    seg_n = SEG_TA;
                    idx_n = '0;
                end
            end
            SEG_TA: begin
                if (rd_q) begin
                    idx_n = '0;
                    seg_n = din ? SEG_FLUSH : SEG_DATA;
                end else if (idx_q == TA_LAST) begin
                    seg_n = SEG_DATA;
                    idx_n = '0;
                end
            end
            SEG_DATA: begin
                cap_in_slot = rd_q;
                shift_wd    = !rd_q;
                if (idx_q == DATA_LAST) begin
                    seg_n = SEG_TAIL;
                    idx_n = '0;
                end
            end
            SEG_TAIL: begin
                fin = 1'b1;
            end
            SEG_FLUSH: begin
                if (idx_q == FLUSH_LAST) begin
                    fin     = 1'b1;
                    fin_err = 1'b1;
                end
            end
            default: begin
                fin = 1'b1;
            end
        endcase
    end

    assign cap_clr   = start && !busy_q;
    assign cap_shift = slot_end && cap_in_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            half_q  <= 1'b0;
            rd_q    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            seg_q   <= SEG_PRE;
            idx_q   <= '0;
            hdr_sr  <= '0;
            wd_sr   <= '0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    half_q <= 1'b0;
                    seg_q  <= SEG_PRE;
                    idx_q  <= '0;
                    rd_q   <= req.rd;
                    hdr_sr <= frame_header(req);
                    wd_sr  <= req.wdata;
                    err_q  <= 1'b0;
                end
            end else if (half_end) begin
                if (!half_q) begin
                    half_q <= 1'b1;
                end else begin
                    half_q <= 1'b0;
                    if (shift_hdr) hdr_sr <= {hdr_sr[HDR_BITS-2:0], 1'b0};
                    if (shift_wd)  wd_sr  <= {wd_sr[DATA_W-2:0], 1'b0};
                    if (fin) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        if (rd_q) begin
                            rdata_q <= fin_err ? '1 : cap_q;
                            err_q   <= fin_err;
                        end
                    end else begin
                        seg_q <= seg_n;
                        idx_q <= idx_n;
                    end
                end
            end
        end
    end

    // pad drive decoded from the slot state; the line is released as 1
    always_comb begin
        pad.mdc  = !busy_q || half_q;
        pad.oe   = 1'b0;
        pad.dout = 1'b1;
        if (busy_q) begin
            unique case (seg_q)
                SEG_PRE: begin
                    pad.oe = 1'b1;
                end
                SEG_HDR: begin
                    pad.oe   = 1'b1;
                    pad.dout = hdr_sr[HDR_BITS-1];
                end
                SEG_TA: begin
                    pad.oe   = !rd_q;
                    pad.dout = rd_q || (idx_q == '0);
                end
                SEG_DATA: begin
                    pad.oe   = !rd_q;
                    pad.dout = rd_q || wd_sr[DATA_W-1];
                end
                default: begin
                    pad.oe = 1'b0;
                end
            endcase
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign err     = err_q;
    assign rd_data = rdata_q;

endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master #(
    parameter int DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        op_read,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        err,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    import mdio_pkg::*;

    mdio_req_t         req;
    pad_drive_t        pad;
    logic              half_end, cap_clr, cap_shift;
    logic [DATA_W-1:0] cap_q;

    assign req = '{rd: op_read, phy: phy_addr, regn: reg_addr, wdata: wr_data};

    mdio_half_timer #(.DIV(DIV)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .half_end (half_end)
    );

    mdio_rx_shift #(.W(DATA_W)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .clr   (cap_clr),
        .shift (cap_shift),
        .din   (mdio_i),
        .q     (cap_q)
    );

    mdio_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req       (req),
        .half_end  (half_end),
        .din       (mdio_i),
        .cap_q     (cap_q),
        .cap_clr   (cap_clr),
        .cap_shift (cap_shift),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rd_data   (rd_data),
        .pad       (pad)
    );

    assign mdc     = pad.mdc;
    assign mdio_o  = pad.dout;
    assign mdio_oe = pad.oe;

endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk #(
    parameter int DIV = 4
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic err,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    localparam int RW = $clog2(DIV + 2) + 1;
    localparam logic [RW-1:0] RMAX = '1;

    // length of the current constant run of mdc, saturating
    logic          mdc_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_q <= 1'b1;
            run_q <= '0;
        end else begin
            mdc_q <= mdc;
            if (mdc != mdc_q)      run_q <= RW'(1);
            else if (run_q != RMAX) run_q <= run_q + 1'b1;
        end
    end

    assert_idle_bus_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mdc && !mdio_oe));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_hold_high_R4: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_err_at_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);

    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_half_len_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (mdc != mdc_q)) |-> (run_q == RW'(DIV)));

endmodule

bind mdio_master mdio_master_chk #(.DIV(DIV)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_read = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy, done, err, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;

    // PHY model state
    logic        phy_en = 1'b0;
    logic        phy_v = 1'b1;
    logic        model_read = 1'b0;
    logic        model_present = 1'b0;
    logic [15:0] model_data = '0;
    int          edges = 0;
    logic        line_bits [0:99];
    logic        oe_bits   [0:99];

    wire mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_v : 1'b1);

    int checks = 0;
    int fails = 0;
    int hold_viol = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mdio_master #(.DIV(DIV)) dut (
        .clk(clk), .rst(rst), .start(start), .op_read(op_read),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .rd_data(rd_data), .err(err),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
    );

    always @(posedge mdc) begin
        if (edges < 100) begin
            line_bits[edges] = mdio_line;
            oe_bits[edges]   = mdio_oe;
        end
        edges = edges + 1;
    end

    // PHY answers only a read aimed at it; changes land while mdc is low
    always @(negedge mdc) begin
        phy_en = 1'b0;
        if (model_read && model_present) begin
            if (edges == 46) begin
                phy_en = 1'b1;
                phy_v  = 1'b0;
            end else if (edges >= 47 && edges <= 62) begin
                phy_en = 1'b1;
                phy_v  = model_data[15 - (edges - 47)];
            end
        end
    end

    // R4 watch: drive must not move across a high phase
    logic p_mdc = 1'b1, p_o = 1'b1, p_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst && mdc && p_mdc && ((mdio_o != p_o) || (mdio_oe != p_oe)))
            hold_viol = hold_viol + 1;
        p_mdc = mdc;
        p_o   = mdio_o;
        p_oe  = mdio_oe;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] resp(input logic [4:0] pa, input logic [4:0] ra);
        return {pa, ra, 6'd0} ^ (16'(ra) * 16'h0911) ^ 16'h5A3C;
    endfunction

    task automatic run_txn(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic present, input logic poke);
        int n;
        int slots;
        int ones;
        int rel;
        logic [13:0] hdr;
        logic [15:0] dat;
        logic [13:0] exp_hdr;
        logic [15:0] exp_rd;

        model_read    = rd;
        model_present = present;
        model_data    = resp(pa, ra);
        exp_rd        = resp(pa, ra);
        exp_hdr       = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
        edges         = 0;

        @(negedge clk);
        op_read  = rd;
        phy_addr = pa;
        reg_addr = ra;
        wr_data  = wd;
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1 && err === 1'b0, "R10 busy set, err cleared", {busy, err}, 2'b10);

        n = 0;
        while (done !== 1'b1 && n < 2000) begin
            if (poke && n == 100) begin
                start    = 1'b1;
                op_read  = ~rd;
                phy_addr = ~pa;
                reg_addr = ~ra;
                wr_data  = ~wd;
            end
            if (poke && n == 101) start = 1'b0;
            @(negedge clk);
            n++;
        end

        slots = rd ? (present ? 64 : 79) : 65;
        check(n == slots * 2 * DIV, "R8 frame duration", n, slots * 2 * DIV);
        check(busy === 1'b0, "R10 busy low with done", busy, 0);
        check(edges == slots, rd ? (present ? "R6 read length" : "R7 no-PHY length")
                                 : "R5 write length", edges, slots);

        ones = 0;
        for (int i = 0; i < 32; i++) if (line_bits[i] === 1'b1 && oe_bits[i] === 1'b1) ones++;
        check(ones == 32, "R1 preamble", ones, 32);

        for (int i = 0; i < 14; i++) hdr[13 - i] = line_bits[32 + i];
        rel = 0;
        for (int i = 0; i < 14; i++) if (oe_bits[32 + i] !== 1'b1) rel++;
        check(hdr[13:10] == exp_hdr[13:10] && rel == 0, "R2 start and direction",
              hdr[13:10], exp_hdr[13:10]);
        check(hdr[9:0] == exp_hdr[9:0], "R3 addresses", hdr[9:0], exp_hdr[9:0]);

        if (!rd) begin
            check(line_bits[46] === 1'b1 && line_bits[47] === 1'b0 &&
                  oe_bits[46] === 1'b1 && oe_bits[47] === 1'b1, "R5 turnaround",
                  {line_bits[46], line_bits[47]}, 2'b10);
            for (int i = 0; i < 16; i++) dat[15 - i] = line_bits[48 + i];
            check(dat == wd, "R5 write data", dat, wd);
            check(oe_bits[64] === 1'b0, "R5 release in tail", oe_bits[64], 0);
        end else if (present) begin
            check(oe_bits[46] === 1'b0, "R6 released at turnaround", oe_bits[46], 0);
            check(rd_data == exp_rd && err === 1'b0, "R6 read value", {err, rd_data},
                  {1'b0, exp_rd});
        end else begin
            rel = 0;
            for (int i = 46; i < 79; i++) if (oe_bits[i] !== 1'b0) rel++;
            check(rel == 0, "R7 released during flush", rel, 0);
            check(rd_data == 16'hFFFF && err === 1'b1, "R7 no-PHY result", {err, rd_data},
                  {1'b1, 16'hFFFF});
        end

        @(negedge clk);
        check(done === 1'b0, "R10 done single cycle", done, 0);
        check(mdc === 1'b1 && mdio_oe === 1'b0, "R11 idle bus", {mdc, mdio_oe}, 2'b10);
        if (poke) begin
            repeat (6) @(negedge clk);
            check(busy === 1'b0 && edges == slots, "R9 start while busy ignored",
                  {busy, 8'(edges)}, {1'b0, 8'(slots)});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && err === 1'b0 && rd_data === 16'h0,
              "R11 reset state", {busy, done, err, rd_data}, 0);
        check(mdc === 1'b1 && mdio_oe === 1'b0, "R11 idle after reset", {mdc, mdio_oe}, 2'b10);

        for (int a = 0; a < 32; a++)
            run_txn(1'b0, 5'(a), 5'(31 - a), 16'(a * 16'h0801) ^ 16'hA5C3, 1'b1, 1'b0);
        for (int r = 0; r < 32; r++)
            run_txn(1'b1, 5'(r) ^ 5'h0A, 5'(r), 16'h0, 1'b1, 1'b0);
        run_txn(1'b1, 5'h1F, 5'h01, 16'h0, 1'b0, 1'b0);
        run_txn(1'b1, 5'h03, 5'h02, 16'h0, 1'b1, 1'b0);
        run_txn(1'b1, 5'h00, 5'h1F, 16'h0, 1'b0, 1'b0);
        run_txn(1'b0, 5'h11, 5'h05, 16'h8001, 1'b1, 1'b1);
        run_txn(1'b1, 5'h06, 5'h0C, 16'h0, 1'b1, 1'b1);
        run_txn(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 1'b1, 1'b0);
        run_txn(1'b0, 5'h00, 5'h00, 16'h0000, 1'b1, 1'b0);

        check(hold_viol == 0, "R4 drive held through high phases", hold_viol, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #3000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule